// File: doc/BRIEF.md
# AXI Wide-to-Narrow Data Width Converter

This block sits between a 128-bit AXI manager and a 32-bit AXI subordinate and re-packs every transfer across the width boundary. The conversion is byte-accurate in both directions.

On the write side, the address channel is forwarded with a burst length that covers the same bytes at the narrow width, and a beat size equal to the narrow bus. Each wide data beat then leaves as a run of narrow beats, lowest 32-bit slice first, and each narrow beat carries the strobe bits of its own slice. The write response returns unchanged. On the read side, the address channel is rescaled the same way. Each group of narrow read beats is gathered into one wide beat, which carries the most severe response of its group.

Only incrementing bursts on aligned addresses with full-width beats are handled. The block keeps at most one write and one read transaction open at a time. Every channel honours VALID/READY back-pressure from either side.

Top module: `axi_width_downsizer`

## Requirements
- R1: After reset, before any write address is accepted, wide write data on offer produces no narrow write beat and is not accepted. No narrow read beat is accepted before a read address has been forwarded.
- R2: A forwarded write address keeps its ID, address and burst type. It carries a narrow length of (L+1)*4-1, where L is the wide length and L is at most 63, and a size code of 3'b010.
- R3: Narrow write beat k of wide beat b carries bits [32j+31:32j] of that wide beat's data and strobe bits [4j+3:4j], where j = k mod 4. Slices are emitted in the order j = 0, 1, 2, 3.
- R4: The narrow write last flag is high only on the fourth slice of the wide beat that is marked last.
- R5: A wide write beat is accepted only together with the handshake of its fourth narrow slice. No narrow write beat is offered before the write address has been accepted on the narrow side.
- R6: After a write address is forwarded, no further write address is offered or accepted until the write response has been handshaken on the wide side. The response ID and response code pass through unchanged.
- R7: A forwarded read address keeps its ID, address and burst type. It carries a narrow length of (L+1)*4-1 and a size code of 3'b010.
- R8: Each wide read beat is made of four consecutive narrow read beats, the first in bits [31:0] and the fourth in bits [127:96]. It carries the read ID of the narrow beats.
- R9: The wide read response is the numerically largest of its four narrow codes (OKAY=0, EXOKAY=1, SLVERR=2, DECERR=3). The wide last flag follows the last flag of the fourth narrow beat.
- R10: While an assembled wide read beat waits for the manager's ready, the fourth narrow beat is not accepted. After a read address is forwarded, no further read address is offered or accepted until the wide beat marked last has been handshaken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| mgr_awvalid | input | 1 | Wide write address valid |
| mgr_awready | output | 1 | Wide write address ready |
| mgr_awid | input | ID_W | Wide write ID |
| mgr_awaddr | input | ADDR_W | Wide write address |
| mgr_awlen | input | LEN_W | Wide write burst length minus one |
| mgr_awburst | input | 2 | Wide write burst type |
| mgr_wvalid | input | 1 | Wide write data valid |
| mgr_wready | output | 1 | Wide write data ready |
| mgr_wdata | input | WIDE_W | Wide write data |
| mgr_wstrb | input | WIDE_W/8 | Wide write strobes |
| mgr_wlast | input | 1 | Wide last write beat |
| mgr_bvalid | output | 1 | Write response valid |
| mgr_bready | input | 1 | Write response ready |
| mgr_bid | output | ID_W | Write response ID |
| mgr_bresp | output | 2 | Write response code |
| mgr_arvalid | input | 1 | Wide read address valid |
| mgr_arready | output | 1 | Wide read address ready |
| mgr_arid | input | ID_W | Wide read ID |
| mgr_araddr | input | ADDR_W | Wide read address |
| mgr_arlen | input | LEN_W | Wide read burst length minus one |
| mgr_arburst | input | 2 | Wide read burst type |
| mgr_rvalid | output | 1 | Wide read data valid |
| mgr_rready | input | 1 | Wide read data ready |
| mgr_rid | output | ID_W | Wide read ID |
| mgr_rdata | output | WIDE_W | Assembled wide read data |
| mgr_rresp | output | 2 | Merged read response |
| mgr_rlast | output | 1 | Wide last read beat |
| sub_awvalid | output | 1 | Narrow write address valid |
| sub_awready | input | 1 | Narrow write address ready |
| sub_awid | output | ID_W | Narrow write ID |
| sub_awaddr | output | ADDR_W | Narrow write address |
| sub_awlen | output | LEN_W | Rescaled write length |
| sub_awsize | output | 3 | Narrow beat size code |
| sub_awburst | output | 2 | Narrow write burst type |
| sub_wvalid | output | 1 | Narrow write data valid |
| sub_wready | input | 1 | Narrow write data ready |
| sub_wdata | output | NARROW_W | Narrow write slice |
| sub_wstrb | output | NARROW_W/8 | Narrow write strobes |
| sub_wlast | output | 1 | Narrow last write beat |
| sub_bvalid | input | 1 | Narrow write response valid |
| sub_bready | output | 1 | Narrow write response ready |
| sub_bid | input | ID_W | Narrow write response ID |
| sub_bresp | input | 2 | Narrow write response code |
| sub_arvalid | output | 1 | Narrow read address valid |
| sub_arready | input | 1 | Narrow read address ready |
| sub_arid | output | ID_W | Narrow read ID |
| sub_araddr | output | ADDR_W | Narrow read address |
| sub_arlen | output | LEN_W | Rescaled read length |
| sub_arsize | output | 3 | Narrow read size code |
| sub_arburst | output | 2 | Narrow read burst type |
| sub_rvalid | input | 1 | Narrow read data valid |
| sub_rready | output | 1 | Narrow read data ready |
| sub_rid | input | ID_W | Narrow read ID |
| sub_rdata | input | NARROW_W | Narrow read data |
| sub_rresp | input | 2 | Narrow read response |
| sub_rlast | input | 1 | Narrow last read beat |

## Verification
The bench drives both manager and subordinate with random stalls. It goes after the sharpest corner cases directly:

- The longest wide burst (length 63, rescaled to 255). A length formula that overflowed or was off by one would end the narrow burst early or late.
- Empty and single-bit strobes. Strobe slices taken at the wrong offset would show up as wrong lanes on the narrow side.
- Wide write data offered before the address. A converter that did not hold it back would leak narrow beats ahead of their address.
- A single DECERR or EXOKAY inside an otherwise clean group of read beats. Merging on the wrong beat, or forgetting a code from an earlier beat, would return the wrong response.
- The manager stalling on a finished wide read beat. A converter that kept accepting would drop the fourth slice.

A second address held on offer during every transaction would be accepted early by a design that did not enforce its single open transaction.

// File: rtl/axi_width_downsizer.sv
module axi_width_downsizer #(
  parameter int ID_W     = 4,
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 8,
  parameter int WIDE_W   = 128,
  parameter int NARROW_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mgr_awvalid,
  output logic                  mgr_awready,
  input  logic [ID_W-1:0]       mgr_awid,
  input  logic [ADDR_W-1:0]     mgr_awaddr,
  input  logic [LEN_W-1:0]      mgr_awlen,
  input  logic [1:0]            mgr_awburst,
  input  logic                  mgr_wvalid,
  output logic                  mgr_wready,
  input  logic [WIDE_W-1:0]     mgr_wdata,
  input  logic [WIDE_W/8-1:0]   mgr_wstrb,
  input  logic                  mgr_wlast,
  output logic                  mgr_bvalid,
  input  logic                  mgr_bready,
  output logic [ID_W-1:0]       mgr_bid,
  output logic [1:0]            mgr_bresp,
  input  logic                  mgr_arvalid,
  output logic                  mgr_arready,
  input  logic [ID_W-1:0]       mgr_arid,
  input  logic [ADDR_W-1:0]     mgr_araddr,
  input  logic [LEN_W-1:0]      mgr_arlen,
  input  logic [1:0]            mgr_arburst,
  output logic                  mgr_rvalid,
  input  logic                  mgr_rready,
  output logic [ID_W-1:0]       mgr_rid,
  output logic [WIDE_W-1:0]     mgr_rdata,
  output logic [1:0]            mgr_rresp,
  output logic                  mgr_rlast,
  output logic                  sub_awvalid,
  input  logic                  sub_awready,
  output logic [ID_W-1:0]       sub_awid,
  output logic [ADDR_W-1:0]     sub_awaddr,
  output logic [LEN_W-1:0]      sub_awlen,
  output logic [2:0]            sub_awsize,
  output logic [1:0]            sub_awburst,
  output logic                  sub_wvalid,
  input  logic                  sub_wready,
  output logic [NARROW_W-1:0]   sub_wdata,
  output logic [NARROW_W/8-1:0] sub_wstrb,
  output logic                  sub_wlast,
  input  logic                  sub_bvalid,
  output logic                  sub_bready,
  input  logic [ID_W-1:0]       sub_bid,
  input  logic [1:0]            sub_bresp,
  output logic                  sub_arvalid,
  input  logic                  sub_arready,
  output logic [ID_W-1:0]       sub_arid,
  output logic [ADDR_W-1:0]     sub_araddr,
  output logic [LEN_W-1:0]      sub_arlen,
  output logic [2:0]            sub_arsize,
  output logic [1:0]            sub_arburst,
  input  logic                  sub_rvalid,
  output logic                  sub_rready,
  input  logic [ID_W-1:0]       sub_rid,
  input  logic [NARROW_W-1:0]   sub_rdata,
  input  logic [1:0]            sub_rresp,
  input  logic                  sub_rlast
);

  localparam int RATIO  = WIDE_W / NARROW_W;
  localparam int SEL_W  = $clog2(RATIO);
  localparam int NBYTES = NARROW_W / 8;
  localparam int HOLD_W = WIDE_W - NARROW_W;
  localparam logic [2:0] NSIZE = 3'($clog2(NBYTES));
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(RATIO - 1);

  logic              wr_open, rd_open;
  logic [SEL_W-1:0]  w_sel, r_sel;
  logic [HOLD_W-1:0] r_hold;
  logic [1:0]        r_worst, r_merge;
  logic              w_fin, r_fin;

  // write address
  assign sub_awvalid = mgr_awvalid & ~wr_open;
  assign mgr_awready = sub_awready & ~wr_open;
  assign sub_awid    = mgr_awid;
  assign sub_awaddr  = mgr_awaddr;
  assign sub_awburst = mgr_awburst;
  assign sub_awsize  = NSIZE;
  assign sub_awlen   = LEN_W'((32'(mgr_awlen) + 1) * RATIO - 1);

  // write data slicing
  assign w_fin      = (w_sel == LAST_SEL);
  assign sub_wvalid = mgr_wvalid & wr_open;
  assign sub_wdata  = mgr_wdata[w_sel*NARROW_W +: NARROW_W];
  assign sub_wstrb  = mgr_wstrb[w_sel*NBYTES +: NBYTES];
  assign sub_wlast  = mgr_wlast & w_fin;
  assign mgr_wready = sub_wready & wr_open & w_fin;

  // write response
  assign mgr_bvalid = sub_bvalid;
  assign sub_bready = mgr_bready;
  assign mgr_bid    = sub_bid;
  assign mgr_bresp  = sub_bresp;

  // read address
  assign sub_arvalid = mgr_arvalid & ~rd_open;
  assign mgr_arready = sub_arready & ~rd_open;
  assign sub_arid    = mgr_arid;
  assign sub_araddr  = mgr_araddr;
  assign sub_arburst = mgr_arburst;
  assign sub_arsize  = NSIZE;
  assign sub_arlen   = LEN_W'((32'(mgr_arlen) + 1) * RATIO - 1);

  // read data packing
  assign r_fin      = (r_sel == LAST_SEL);
  assign r_merge    = (r_sel == '0) ? sub_rresp :
                      ((sub_rresp > r_worst) ? sub_rresp : r_worst);
  assign sub_rready = rd_open & (r_fin ? mgr_rready : 1'b1);
  assign mgr_rvalid = sub_rvalid & rd_open & r_fin;
  assign mgr_rdata  = {sub_rdata, r_hold};
  assign mgr_rresp  = r_merge;
  assign mgr_rid    = sub_rid;
  assign mgr_rlast  = sub_rlast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_open <= 1'b0;
      w_sel   <= '0;
    end else begin
      if (sub_awvalid && sub_awready) wr_open <= 1'b1;
      else if (mgr_bvalid && mgr_bready) wr_open <= 1'b0;
      if (sub_wvalid && sub_wready) w_sel <= w_sel + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_open <= 1'b0;
      r_sel   <= '0;
      r_hold  <= '0;
      r_worst <= 2'b00;
    end else begin
      if (sub_arvalid && sub_arready) rd_open <= 1'b1;
      else if (mgr_rvalid && mgr_rready && mgr_rlast) rd_open <= 1'b0;
      if (sub_rvalid && sub_rready) begin
        r_sel   <= r_sel + 1'b1;
        r_worst <= r_merge;
        if (!r_fin) r_hold <= HOLD_W'({sub_rdata, r_hold} >> NARROW_W);
      end
    end
  end

endmodule

// File: rtl/axi_width_downsizer_props.sv
module axi_width_downsizer_props #(
  parameter int LEN_W = 8,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LEN_W-1:0] mgr_awlen,
  input logic             sub_awvalid,
  input logic             sub_awready,
  input logic [LEN_W-1:0] sub_awlen,
  input logic [2:0]       sub_awsize,
  input logic             mgr_wvalid,
  input logic             mgr_wready,
  input logic             mgr_wlast,
  input logic             sub_wvalid,
  input logic             sub_wready,
  input logic             sub_wlast,
  input logic [LEN_W-1:0] mgr_arlen,
  input logic             sub_arvalid,
  input logic             sub_arready,
  input logic [LEN_W-1:0] sub_arlen,
  input logic             mgr_rvalid,
  input logic             mgr_rready,
  input logic [1:0]       mgr_rresp,
  input logic             mgr_rlast,
  input logic             sub_rvalid,
  input logic             sub_rready,
  input logic [1:0]       sub_rresp,
  input logic             sub_rlast
);

  p_awlen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sub_awvalid |-> (sub_awlen == LEN_W'({mgr_awlen, {SEL_W{1'b1}}}) && sub_awsize == 3'd2));

  p_wide_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mgr_wvalid && mgr_wready) |-> (sub_wvalid && sub_wready));

  p_wlast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_wvalid && sub_wlast) |-> mgr_wlast);

  p_single_aw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_awvalid && sub_awready) |=> !sub_awvalid);

  p_arlen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sub_arvalid |-> sub_arlen == LEN_W'({mgr_arlen, {SEL_W{1'b1}}}));

  p_rlast_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mgr_rvalid && mgr_rlast) |-> (sub_rvalid && sub_rlast));

  p_rresp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mgr_rvalid |-> mgr_rresp >= sub_rresp);

  p_rstall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mgr_rvalid && !mgr_rready) |-> !sub_rready);

  p_single_ar_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_arvalid && sub_arready) |=> !sub_arvalid);

endmodule

bind axi_width_downsizer axi_width_downsizer_props #(.LEN_W(LEN_W), .SEL_W(SEL_W)) u_props (
  .clk(clk), .rst_n(rst_n), .mgr_awlen(mgr_awlen),
  .sub_awvalid(sub_awvalid), .sub_awready(sub_awready), .sub_awlen(sub_awlen),
  .sub_awsize(sub_awsize), .mgr_wvalid(mgr_wvalid), .mgr_wready(mgr_wready),
  .mgr_wlast(mgr_wlast), .sub_wvalid(sub_wvalid), .sub_wready(sub_wready),
  .sub_wlast(sub_wlast), .mgr_arlen(mgr_arlen), .sub_arvalid(sub_arvalid),
  .sub_arready(sub_arready), .sub_arlen(sub_arlen), .mgr_rvalid(mgr_rvalid),
  .mgr_rready(mgr_rready), .mgr_rresp(mgr_rresp), .mgr_rlast(mgr_rlast),
  .sub_rvalid(sub_rvalid), .sub_rready(sub_rready), .sub_rresp(sub_rresp),
  .sub_rlast(sub_rlast)
);

// File: tb/axi_width_downsizer_test.sv
`timescale 1ns/1ps
module axi_width_downsizer_test;
  localparam int PERIOD = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic mgr_awvalid, mgr_awready; logic [3:0] mgr_awid; logic [31:0] mgr_awaddr;
  logic [7:0] mgr_awlen; logic [1:0] mgr_awburst;
  logic mgr_wvalid, mgr_wready; logic [127:0] mgr_wdata; logic [15:0] mgr_wstrb; logic mgr_wlast;
  logic mgr_bvalid, mgr_bready; logic [3:0] mgr_bid; logic [1:0] mgr_bresp;
  logic mgr_arvalid, mgr_arready; logic [3:0] mgr_arid; logic [31:0] mgr_araddr;
  logic [7:0] mgr_arlen; logic [1:0] mgr_arburst;
  logic mgr_rvalid, mgr_rready; logic [3:0] mgr_rid; logic [127:0] mgr_rdata;
  logic [1:0] mgr_rresp; logic mgr_rlast;
  logic sub_awvalid, sub_awready; logic [3:0] sub_awid; logic [31:0] sub_awaddr;
  logic [7:0] sub_awlen; logic [2:0] sub_awsize; logic [1:0] sub_awburst;
  logic sub_wvalid, sub_wready; logic [31:0] sub_wdata; logic [3:0] sub_wstrb; logic sub_wlast;
  logic sub_bvalid, sub_bready; logic [3:0] sub_bid; logic [1:0] sub_bresp;
  logic sub_arvalid, sub_arready; logic [3:0] sub_arid; logic [31:0] sub_araddr;
  logic [7:0] sub_arlen; logic [2:0] sub_arsize; logic [1:0] sub_arburst;
  logic sub_rvalid, sub_rready; logic [3:0] sub_rid; logic [31:0] sub_rdata;
  logic [1:0] sub_rresp; logic sub_rlast;

  axi_width_downsizer uut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [127:0] wd [0:63];
  logic [15:0]  ws [0:63];
  logic [31:0]  rd [0:255];
  logic [1:0]   rr [0:255];
  bit b_done, r_done;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_len(input logic [7:0] l);
    return 8'((int'(l) + 1) * 4 - 1);
  endfunction

  function automatic logic [1:0] worst4(input int base);
    logic [1:0] m = rr[base];
    for (int i = 1; i < 4; i++) if (rr[base+i] > m) m = rr[base+i];
    return m;
  endfunction

  function automatic bit roll(input int pct);
    return $urandom_range(99) < pct;
  endfunction

  task automatic do_write(input logic [3:0] id, input logic [31:0] addr, input logic [7:0] len,
                          input logic [1:0] bresp, input int gap, input int rdy);
    b_done = 0;
    fork
      begin : mgr_aw
        bit hs = 0;
        @(negedge clk);
        mgr_awvalid = 1; mgr_awid = id; mgr_awaddr = addr; mgr_awlen = len; mgr_awburst = 2'b01;
        while (!hs) begin #8; hs = mgr_awready; @(negedge clk); end
        mgr_awid = ~id; mgr_awaddr = addr + 32'h1000; mgr_awlen = 8'd3;
        while (!b_done) @(negedge clk);
        mgr_awvalid = 0;
      end
      begin : mgr_w
        @(negedge clk);
        for (int b = 0; b <= int'(len); b++) begin
          bit hs = 0;
          while (roll(gap)) begin mgr_wvalid = 0; @(negedge clk); end
          mgr_wvalid = 1; mgr_wdata = wd[b]; mgr_wstrb = ws[b]; mgr_wlast = (b == int'(len));
          while (!hs) begin #8; hs = mgr_wready; @(negedge clk); end
        end
        mgr_wvalid = 0; mgr_wlast = 0;
      end
      begin : mgr_b
        bit hs = 0;
        while (!hs) begin
          @(negedge clk); mgr_bready = roll(rdy); #8;
          if (mgr_bvalid && mgr_bready) begin
            hs = 1;
            chk(mgr_bid == id, "R6", "bid", 128'(mgr_bid), 128'(id));
            chk(mgr_bresp == bresp, "R6", "bresp", 128'(mgr_bresp), 128'(bresp));
            b_done = 1;
          end
        end
        @(negedge clk); mgr_bready = 0;
      end
      begin : sub_side
        bit hs = 0, early = 0, leak = 0;
        int n = (int'(len) + 1) * 4;
        @(negedge clk);
        while (!hs) begin
          sub_awready = roll(rdy); #8;
          if (sub_awvalid && sub_awready) begin
            hs = 1;
            chk(sub_awlen == exp_len(len), "R2", "awlen", 128'(sub_awlen), 128'(exp_len(len)));
            chk(sub_awsize == 3'b010, "R2", "awsize", 128'(sub_awsize), 128'(3'b010));
            chk(sub_awid == id && sub_awaddr == addr && sub_awburst == 2'b01, "R2", "aw id/addr/burst",
                {sub_awid, sub_awaddr, sub_awburst}, {id, addr, 2'b01});
          end else if (sub_wvalid) early = 1;
          @(negedge clk);
        end
        sub_awready = 0;
        chk(!early, "R5", "narrow W before AW", 128'(early), 128'(0));
        for (int k = 0; k < n; k++) begin
          hs = 0;
          while (!hs) begin
            sub_wready = roll(rdy); #8;
            if (sub_awvalid) leak = 1;
            if (sub_wvalid && sub_wready) begin
              hs = 1;
              chk(sub_wdata == wd[k/4][(k%4)*32 +: 32], "R3", "wdata slice",
                  128'(sub_wdata), 128'(wd[k/4][(k%4)*32 +: 32]));
              chk(sub_wstrb == ws[k/4][(k%4)*4 +: 4], "R3", "wstrb slice",
                  128'(sub_wstrb), 128'(ws[k/4][(k%4)*4 +: 4]));
              chk(sub_wlast == (k == n-1), "R4", "wlast", 128'(sub_wlast), 128'(k == n-1));
            end
            @(negedge clk);
          end
        end
        sub_wready = 0;
        sub_bvalid = 1; sub_bid = id; sub_bresp = bresp;
        hs = 0;
        while (!hs) begin
          #8; if (sub_awvalid) leak = 1;
          hs = sub_bready; @(negedge clk);
        end
        sub_bvalid = 0;
        chk(!leak, "R6", "second AW during open write", 128'(leak), 128'(0));
      end
    join
  endtask

  task automatic do_read(input logic [3:0] id, input logic [31:0] addr, input logic [7:0] len,
                         input int errpos, input logic [1:0] errval, input int gap, input int rdy);
    int n = (int'(len) + 1) * 4;
    for (int k = 0; k < n; k++) begin
      int r = $urandom_range(7);
      rd[k] = $urandom;
      if (errpos >= 0) rr[k] = (k == errpos) ? errval : 2'b00;
      else rr[k] = (r < 5) ? 2'd0 : 2'(r - 4);
    end
    r_done = 0;
    fork
      begin : mgr_ar
        bit hs = 0;
        @(negedge clk);
        mgr_arvalid = 1; mgr_arid = id; mgr_araddr = addr; mgr_arlen = len; mgr_arburst = 2'b01;
        while (!hs) begin #8; hs = mgr_arready; @(negedge clk); end
        mgr_arid = ~id; mgr_araddr = addr + 32'h2000; mgr_arlen = 8'd1;
        while (!r_done) @(negedge clk);
        mgr_arvalid = 0;
      end
      begin : mgr_r
        bit stall_leak = 0;
        for (int b = 0; b <= int'(len); b++) begin
          bit hs = 0;
          while (!hs) begin
            @(negedge clk); mgr_rready = roll(rdy); #8;
            if (mgr_rvalid && !mgr_rready && sub_rready) stall_leak = 1;
            if (mgr_rvalid && mgr_rready) begin
              logic [127:0] e = {rd[4*b+3], rd[4*b+2], rd[4*b+1], rd[4*b]};
              hs = 1;
              chk(mgr_rdata == e, "R8", "rdata pack", mgr_rdata, e);
              chk(mgr_rid == id, "R8", "rid", 128'(mgr_rid), 128'(id));
              chk(mgr_rresp == worst4(4*b), "R9", "rresp merge", 128'(mgr_rresp), 128'(worst4(4*b)));
              chk(mgr_rlast == (b == int'(len)), "R9", "rlast", 128'(mgr_rlast), 128'(b == int'(len)));
              if (b == int'(len)) r_done = 1;
            end
          end
        end
        @(negedge clk); mgr_rready = 0;
        chk(!stall_leak, "R10", "narrow beat taken during wide stall", 128'(stall_leak), 128'(0));
      end
      begin : sub_side
        bit hs = 0, leak = 0;
        @(negedge clk);
        while (!hs) begin
          sub_arready = roll(rdy); #8;
          if (sub_arvalid && sub_arready) begin
            hs = 1;
            chk(sub_arlen == exp_len(len), "R7", "arlen", 128'(sub_arlen), 128'(exp_len(len)));
            chk(sub_arsize == 3'b010 && sub_arid == id && sub_araddr == addr && sub_arburst == 2'b01,
                "R7", "ar size/id/addr/burst", {sub_arsize, sub_arid, sub_araddr, sub_arburst},
                {3'b010, id, addr, 2'b01});
          end
          @(negedge clk);
        end
        sub_arready = 0;
        for (int k = 0; k < n; k++) begin
          while (roll(gap)) begin
            sub_rvalid = 0; #8; if (sub_arvalid) leak = 1; @(negedge clk);
          end
          sub_rvalid = 1; sub_rdata = rd[k]; sub_rresp = rr[k]; sub_rid = id; sub_rlast = (k == n-1);
          hs = 0;
          while (!hs) begin #8; if (sub_arvalid) leak = 1; hs = sub_rready; @(negedge clk); end
        end
        sub_rvalid = 0; sub_rlast = 0;
        chk(!leak, "R10", "second AR during open read", 128'(leak), 128'(0));
      end
    join
  endtask

  task automatic fill_wr(input logic [7:0] len, input int mode);
    for (int b = 0; b <= int'(len); b++) begin
      wd[b] = {$urandom, $urandom, $urandom, $urandom};
      case (mode)
        1: ws[b] = 16'h0000;
        2: ws[b] = 16'(1 << (b % 16));
        default: ws[b] = 16'($urandom);
      endcase
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    {mgr_awvalid, mgr_awid, mgr_awaddr, mgr_awlen, mgr_awburst} = '0;
    {mgr_wvalid, mgr_wdata, mgr_wstrb, mgr_wlast, mgr_bready} = '0;
    {mgr_arvalid, mgr_arid, mgr_araddr, mgr_arlen, mgr_arburst, mgr_rready} = '0;
    {sub_awready, sub_wready, sub_bvalid, sub_bid, sub_bresp, sub_arready} = '0;
    {sub_rvalid, sub_rid, sub_rdata, sub_rresp, sub_rlast} = '0;
    mgr_wvalid = 1; mgr_wlast = 1; mgr_wdata = {4{32'hA5A5_5A5A}}; mgr_wstrb = 16'hFFFF;
    sub_wready = 1; sub_rvalid = 1;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    #8;
    chk(!sub_wvalid, "R1", "sub_wvalid after reset", 128'(sub_wvalid), 128'(0));
    chk(!mgr_wready, "R1", "mgr_wready after reset", 128'(mgr_wready), 128'(0));
    chk(!sub_rready, "R1", "sub_rready after reset", 128'(sub_rready), 128'(0));
    chk(!sub_awvalid && !sub_arvalid && !mgr_rvalid, "R1", "idle valids",
        {sub_awvalid, sub_arvalid, mgr_rvalid}, 128'(0));
    @(negedge clk);
    mgr_wvalid = 0; mgr_wlast = 0; sub_wready = 0; sub_rvalid = 0;

    fill_wr(8'd0, 0); do_write(4'h3, 32'h0000_1000, 8'd0, 2'b00, 0, 100);
    fill_wr(8'd63, 0); do_write(4'hC, 32'h0004_0000, 8'd63, 2'b10, 20, 70);
    fill_wr(8'd5, 1); do_write(4'h1, 32'h0000_2000, 8'd5, 2'b11, 30, 50);
    fill_wr(8'd17, 2); do_write(4'h6, 32'h0000_3000, 8'd17, 2'b01, 10, 40);
    do_read(4'h2, 32'h0000_8000, 8'd0, 2, 2'b11, 0, 100);
    do_read(4'h9, 32'h0000_9000, 8'd3, 5, 2'b01, 20, 50);
    do_read(4'h4, 32'h000A_0000, 8'd63, -1, 2'b00, 10, 60);
    do_read(4'hE, 32'h0000_B000, 8'd2, 11, 2'b10, 0, 10);
    for (int t = 0; t < 25; t++) begin
      logic [7:0] l = 8'($urandom_range(15));
      fill_wr(l, 0);
      do_write(4'($urandom), {$urandom} & 32'hFFFF_FFF0, l, 2'($urandom), $urandom_range(50),
               $urandom_range(30, 100));
      do_read(4'($urandom), {$urandom} & 32'hFFFF_FFF0, 8'($urandom_range(15)), -1, 2'b00,
              $urandom_range(50), $urandom_range(30, 100));
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule